// File: doc/BRIEF.md
# Paged System Address Decoder

This block sits between a bus master that issues single-byte reads and writes on a 24-bit address and two memories: a 128 KiB work RAM and a read-only cartridge ROM. It decides where each access goes, turns the global address into a local memory address and gates the write strobe. It also returns read data, or zero when no memory backs the address. Routing is decided per 4 KiB page, which is the top twelve address bits. The page decode is computed, not stored.

The RAM occupies the 128 KiB that starts at 0x7E0000, so banks 0x7E and 0x7F map onto it linearly. The lowest 8 KiB of bank 0 is a second window onto the first two 4 KiB slices of that RAM. The ROM appears in the upper half (offsets 0x8000-0xFFFF) of banks 0x00-0x1F and of their images at 0x80-0x9F. Each such bank contributes a consecutive 32 KiB slice of ROM, and the result wraps at the ROM size. Both memories are synchronous, so read data comes back one clock after the request.

Top module: `page_bus_router`

## Requirements
- R1: Routing is decided per 4 KiB page from address bits [23:12]; every byte within one page goes to the same target.
- R2: Addresses 0x7E0000-0x7FFFFF reach the RAM with local address equal to address bits [16:0].
- R3: Bank 0 offsets 0x0000-0x1FFF reach RAM locations 0x00000-0x01FFF; data written through one window reads back through the other, and bank 0 offsets 0x2000-0x7FFF are unmapped.
- R4: Offsets 0x8000-0xFFFF of banks 0x00-0x1F and 0x80-0x9F are ROM reads; the same offsets in banks 0x20-0x7D and 0xA0-0xFF are unmapped.
- R5: The ROM local address is (((bank & 0x7F) * 0x8000) | (address & 0x7FFF)) truncated to log2(ROM_BYTES) bits; ROM_BYTES is a power of two, 1 MiB by default.
- R6: A write to a ROM address never raises the ROM enable or the RAM write strobe, and the ROM data read afterwards is unchanged.
- R7: A read from an unmapped page returns 0x00; a write to an unmapped page raises no memory strobe and changes no RAM location.
- R8: rsp_valid is high in the cycle after an accepted read and only then, with rsp_data valid in that same cycle; rsp_valid is low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Global byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data returned this cycle |
| rsp_data | output | 8 | Read data (0x00 for unmapped) |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 17 | RAM local address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one clock after ram_en |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | log2(ROM_BYTES) | ROM local address |
| rom_rdata | input | 8 | ROM read data, one clock after rom_en |

## Verification
The bench aims at the page edges where the target changes: offset 0x1FFF against 0x2000 in bank 0, 0x7FFF against 0x8000 in ROM banks, and banks 0x1F/0x20, 0x7D/0x7E and 0x9F/0xA0. An off-by-one decode would return ROM or RAM bytes where zero is due, or the reverse. Mirror coherency is checked in both directions. A design that gave the low window its own storage would return stale data through bank 0x7E. Writes aimed at ROM and at unmapped pages are watched on the strobe ports and read back afterwards, which catches a design that leaks them into RAM. The ROM read pattern depends on the address, so a wrong bank fold shows up as a wrong byte.

// File: rtl/page_bus_router.sv
module page_bus_router #(
  parameter int ROM_BYTES = 1 << 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [23:0]                  req_addr,
  input  logic [7:0]                   req_wdata,
  output logic                         rsp_valid,
  output logic [7:0]                   rsp_data,
  output logic                         ram_en,
  output logic                         ram_we,
  output logic [16:0]                  ram_addr,
  output logic [7:0]                   ram_wdata,
  input  logic [7:0]                   ram_rdata,
  output logic                         rom_en,
  output logic [$clog2(ROM_BYTES)-1:0] rom_addr,
  input  logic [7:0]                   rom_rdata
);
  localparam int ROM_AW = $clog2(ROM_BYTES);

  typedef enum logic [1:0] {TGT_NONE, TGT_RAM, TGT_ROM} tgt_t;

  function automatic tgt_t page_target(input logic [11:0] pg);
    logic [7:0] bank;
    bank = pg[11:4];
    if (bank[7:1] == 7'h3F)                 return TGT_RAM;
    if (bank == 8'h00 && pg[3:1] == 3'b000) return TGT_RAM;
    if (bank[6:5] == 2'b00 && pg[3])        return TGT_ROM;
    return TGT_NONE;
  endfunction

  tgt_t tgt, sel_q;
  assign tgt = page_target(req_addr[23:12]);

  assign ram_en    = req_valid && tgt == TGT_RAM;
  assign ram_we    = ram_en && req_write;
  assign ram_addr  = req_addr[16:0];
  assign ram_wdata = req_wdata;
  assign rom_en    = req_valid && !req_write && tgt == TGT_ROM;
  assign rom_addr  = (ROM_AW)'({req_addr[22:16], req_addr[14:0]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      sel_q     <= TGT_NONE;
    end else begin
      rsp_valid <= req_valid && !req_write;
      sel_q     <= (req_valid && !req_write) ? tgt : TGT_NONE;
    end
  end

  assign rsp_data = (sel_q == TGT_RAM) ? ram_rdata :
                    (sel_q == TGT_ROM) ? rom_rdata : 8'h00;

  assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_en && rom_en));
  assert_ram_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[23:17] == 7'h3F) |-> (ram_en && ram_addr == req_addr[16:0]));
  assert_rom_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !rom_en);
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !ram_en && !rom_en) |=> (rsp_data == 8'h00));
  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/tb_page_bus_router.sv
module tb_page_bus_router;
  localparam int ROM_BYTES = 1 << 20;
  localparam int ROM_AW = $clog2(ROM_BYTES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid, ram_en, ram_we, rom_en;
  logic [7:0] rsp_data, ram_wdata, ram_rdata, rom_rdata;
  logic [16:0] ram_addr;
  logic [ROM_AW-1:0] rom_addr;

  int total = 0, bad = 0;
  logic [7:0] mem [0:131071];
  logic [7:0] shadow [0:131071];

  always #10 clk = ~clk;

  page_bus_router #(.ROM_BYTES(ROM_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .rom_en(rom_en),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata));

  function automatic logic [7:0] rom_byte(input logic [31:0] a);
    return a[7:0] ^ a[19:12] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr];
    end
    if (rom_en) rom_rdata <= rom_byte(32'(rom_addr));
  end

  // 0 none, 1 RAM, 2 ROM
  function automatic int kind(input logic [23:0] a);
    int bank, off;
    bank = int'(a[23:16]); off = int'(a[15:0]);
    if (bank == 'h7E || bank == 'h7F) return 1;
    if (bank == 0 && off < 'h2000) return 1;
    if ((bank <= 'h1F || (bank >= 'h80 && bank <= 'h9F)) && off >= 'h8000) return 2;
    return 0;
  endfunction

  function automatic int ram_idx(input logic [23:0] a);
    if (a[23:16] == 8'h00) return int'(a[15:0]);
    return int'(a) - 'h7E0000;
  endfunction

  function automatic logic [31:0] rom_idx(input logic [23:0] a);
    return ((32'(a[23:16]) & 32'h7F) * 32'h8000 | (32'(a) & 32'h7FFF)) & (ROM_BYTES - 1);
  endfunction

  function automatic logic [7:0] expect_rd(input logic [23:0] a);
    case (kind(a))
      1: return shadow[ram_idx(a)];
      2: return rom_byte(rom_idx(a));
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [23:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    check(ram_we == (kind(a) == 1), req, int'(ram_we), int'(kind(a) == 1));
    check(!rom_en, req, int'(rom_en), 0);
    if (kind(a) == 1) shadow[ram_idx(a)] = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(!rsp_valid, {req, " R8"}, int'(rsp_valid), 0);
  endtask

  task automatic do_read(input logic [23:0] a, input string req);
    logic [7:0] e;
    e = expect_rd(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_data == e, req, int'({rsp_valid, rsp_data}), int'({1'b1, e}));
  endtask

  initial begin
    for (int i = 0; i < 131072; i++) begin mem[i] = 8'h00; shadow[i] = 8'h00; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && !ram_en && !rom_en, "R8 reset", int'({rsp_valid, ram_en, rom_en}), 0);
    rst_n = 1'b1;

    do_write(24'h7E1234, 8'hA5, "R2");
    do_read (24'h7E1234, "R2");
    do_write(24'h7FFFFF, 8'h3C, "R2");
    do_read (24'h7FFFFF, "R2");
    do_write(24'h000123, 8'h77, "R3");
    do_read (24'h7E0123, "R3");
    do_write(24'h7E1FFF, 8'h19, "R3");
    do_read (24'h001FFF, "R3");
    do_write(24'h002000, 8'hEE, "R3");
    do_read (24'h002000, "R3");
    do_read (24'h7E2000, "R3");
    do_read (24'h001000, "R1");
    do_read (24'h000FFF, "R1");
    do_read (24'h008000, "R4");
    do_read (24'h007FFF, "R4");
    do_read (24'h1FFFFF, "R5");
    do_read (24'h80FFFF, "R5");
    do_read (24'h9F8000, "R5");
    do_read (24'h058ABC, "R5");
    do_read (24'h208000, "R4");
    do_read (24'hA0FFFF, "R4");
    do_read (24'h7DFFFF, "R4");
    do_write(24'h808000, 8'h00, "R6");
    do_read (24'h808000, "R6");
    do_read (24'h008000, "R6");
    do_write(24'h450010, 8'h99, "R7");
    do_read (24'h450010, "R7");
    do_read (24'h7E0010, "R7");
    @(negedge clk);
    check(!rsp_valid, "R8 idle", int'(rsp_valid), 0);

    for (int n = 0; n < 1500; n++) begin
      logic [7:0] bk;
      logic [23:0] a;
      case ($urandom % 10)
        0: bk = 8'h00; 1: bk = 8'h1F; 2: bk = 8'h20; 3, 4: bk = 8'h7E;
        5: bk = 8'h7F; 6: bk = 8'h80; 7: bk = 8'h9F; 8: bk = 8'hA0;
        default: bk = 8'($urandom);
      endcase
      a = {bk, 16'($urandom)};
      if (bk == 8'h7E && ($urandom % 2) == 0) a[15:13] = 3'b000;
      if (bk == 8'h00 && ($urandom % 2) == 0) a[15:13] = 3'b000;
      if ($urandom % 2) do_write(a, 8'($urandom), "R1 random");
      else do_read(a, "R1 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    bad++; total++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule